// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block predicts where an indirect jump or call will land when its destination comes from a register or from memory. A front end presents the fetch PC of an indirect branch on the lookup side. One cycle later the block answers with a hit flag and a predicted target. When the branch resolves, the back end reports the PC, the real destination and whether the earlier prediction was wrong. The block then trains its tables from that report.

Two structures are used. The first is a set-associative target table. Its set index mixes PC bits with a short history of recent indirect-branch destinations, and each history event is a small multi-bit target identifier. Because of this, one jump that rotates through several destinations gets a separate entry for each history context. The second is a last-target table indexed by the PC alone. It is the fallback whenever the history-indexed entry is missing or not yet trusted.

The lookup side is a valid-only stream with no back-pressure. A strobe is always accepted, and its response is presented for exactly one cycle on the next clock. The consumer must take it then, because the block has no ready input. The update side is also valid-only and is always accepted.

Top module: `ibp_predictor`

## Requirements
- R1: A synchronous reset invalidates every entry of both tables and zeroes the history. A lookup after reset returns rsp_hit = 0, and rsp_valid stays low while reset is held.
- R2: A lookup strobe in cycle t produces rsp_valid = 1 in cycle t+1 only. Without a strobe, rsp_valid is low.
- R3: When neither table holds a usable entry for the PC, the response has rsp_hit = 0 and rsp_target = 0.
- R4: When the history-indexed entry is absent or its confidence is below 2, the prediction is the destination most recently reported for that PC. The last-target table is indexed by PC[5:2] and tagged with PC[15:6].
- R5: A target-table entry that matches the PC and the history, with confidence at least 2, supplies the predicted target.
- R6: An update that misses the target table allocates an entry only when the mispredict flag is set, with confidence 1. An update that hits with the same target raises confidence, saturating at 3. A hit with a different target replaces the target and sets confidence to 1.
- R7: The history holds 4 events of 2 bits each. Every update shifts in target[3:2] at the low end. The set index is PC[5:2] XOR hist[3:0] XOR hist[7:4], and the tag is PC[15:6] together with the full 8-bit history.
- R8: A jump that alternates between two targets is predicted correctly once each history context has been seen three times.
- R9: A jump that cycles through three targets with period 3 is predicted correctly once each history context has been seen three times.
- R10: Allocation fills the lowest-numbered invalid way of the set. In a full set, it evicts the way least recently touched by an update.
- R11: When a lookup and an update occur in the same cycle, the lookup sees the table contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup strobe |
| lk_pc | input | PC_W | PC of the indirect branch being fetched |
| rsp_valid | output | 1 | Response present (one cycle after lk_valid) |
| rsp_hit | output | 1 | A target prediction is available |
| rsp_target | output | PC_W | Predicted target, zero when rsp_hit is low |
| up_valid | input | 1 | Resolved indirect branch report |
| up_pc | input | PC_W | PC of the resolved branch |
| up_target | input | PC_W | Actual destination |
| up_mispred | input | 1 | Earlier prediction was missing or wrong |

## Verification
The main function is exercised with several destination patterns, each chosen to expose a different behaviour:
- A branch with one steady target separates the last-target path from the trained history path.
- A target switch shows the confidence reset and the fallback taking over.
- A two-way alternation and a three-way rotation show that a multi-bit history tells contexts apart. The outputs switch from the last-target guess to the correct target on the exact execution the confidence rule predicts.
- Five PCs colliding in one set expose the victim choice.
- A lookup and an update driven into the same set in the same cycle expose the read-before-write ordering.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  localparam int CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_NEW = conf_t'(1);
  localparam conf_t CONF_USE = conf_t'(2);

  function automatic conf_t conf_bump(input conf_t c);
    return (c == '1) ? c : c + conf_t'(1);
  endfunction
endpackage

// File: rtl/ibp_hist.sv
module ibp_hist #(
  parameter int ID_W   = 2,
  parameter int EVENTS = 4,
  parameter int FOLD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic [ID_W-1:0]          id_in,
  output logic [ID_W*EVENTS-1:0]   hist,
  output logic [FOLD_W-1:0]        folded
);
  localparam int H_W = ID_W * EVENTS;

  logic [H_W-1:0] hist_r;

  generate
    if (EVENTS > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) hist_r <= '0;
        else if (shift_en) hist_r <= {hist_r[H_W-ID_W-1:0], id_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist_r <= '0;
        else if (shift_en) hist_r <= id_in;
      end
    end
  endgenerate

  always_comb begin
    folded = '0;
    for (int i = 0; i < H_W; i++) begin
      folded[i % FOLD_W] = folded[i % FOLD_W] ^ hist_r[i];
    end
  end

  assign hist = hist_r;
endmodule

// File: rtl/ibp_fallback.sv
module ibp_fallback #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 10,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [TGT_W-1:0] rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_target
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [TGT_W-1:0] tgt_q [N];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
    end
  end

  always_comb begin
    rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_target = rd_hit ? tgt_q[rd_idx] : '0;
  end
endmodule

// File: rtl/ibp_target_table.sv
module ibp_target_table
  import ibp_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  parameter int TGT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(SETS)-1:0]  rd_set,
  input  logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_hit,
  output logic [TGT_W-1:0]         rd_target,
  input  logic                     wr_en,
  input  logic                     wr_alloc,
  input  logic [$clog2(SETS)-1:0]  wr_set,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [TGT_W-1:0]         wr_target
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [TGT_W-1:0] tgt_q [SETS][WAYS];
  conf_t            conf_q [SETS][WAYS];

  logic             wr_hit, have_free, touch, same_tgt;
  logic [WAY_W-1:0] hit_way, vic_way, sel_way;

  // Lookup read: trusted entries only
  always_comb begin
    rd_hit    = 1'b0;
    rd_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag) &&
          (conf_q[rd_set][w] >= CONF_USE)) begin
        rd_hit    = 1'b1;
        rd_target = tgt_q[rd_set][w];
      end
    end
  end

  // Update path: tag match, then victim choice
  always_comb begin
    wr_hit  = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!wr_hit && vld_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag)) begin
        wr_hit  = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    have_free = 1'b0;
    vic_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!have_free && !vld_q[wr_set][w]) begin
        have_free = 1'b1;
        vic_way   = WAY_W'(w);
      end
    end
    if (!have_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[wr_set][w] == WAY_W'(WAYS-1)) vic_way = WAY_W'(w);
      end
    end
    sel_way  = wr_hit ? hit_way : vic_way;
    touch    = wr_en && (wr_hit || wr_alloc);
    same_tgt = wr_hit && (tgt_q[wr_set][hit_way] == wr_target);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (touch) begin
      vld_q[wr_set][sel_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way)
          age_q[wr_set][w] <= '0;
        else if (age_q[wr_set][w] < age_q[wr_set][sel_way])
          age_q[wr_set][w] <= age_q[wr_set][w] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (touch) begin
      tag_q[wr_set][sel_way] <= wr_tag;
      if (same_tgt) begin
        conf_q[wr_set][sel_way] <= conf_bump(conf_q[wr_set][sel_way]);
      end else begin
        tgt_q[wr_set][sel_way]  <= wr_target;
        conf_q[wr_set][sel_way] <= CONF_NEW;
      end
    end
  end
endmodule

// File: rtl/ibp_predictor.sv
module ibp_predictor #(
  parameter int PC_W        = 32,
  parameter int SETS        = 16,
  parameter int WAYS        = 4,
  parameter int HIST_EVENTS = 4,
  parameter int ID_W        = 2,
  parameter int TAG_PC_W    = 10,
  parameter int FB_IDX_W    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PC_W-1:0] rsp_target,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_mispred
);
  localparam int SET_W  = $clog2(SETS);
  localparam int H_W    = ID_W * HIST_EVENTS;
  localparam int TAG_W  = TAG_PC_W + H_W;
  localparam int PC_TOP = 2 + SET_W + TAG_PC_W;
  localparam int FB_TOP = 2 + FB_IDX_W + TAG_PC_W;

  logic [H_W-1:0]   hist_q;
  logic [SET_W-1:0] folded;
  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             tt_hit, fb_hit;
  logic [PC_W-1:0]  tt_tgt, fb_tgt, pick_tgt;
  logic             rsp_valid_q, rsp_hit_q;
  logic [PC_W-1:0]  rsp_tgt_q;
  logic             unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc[1:0], up_pc[1:0], lk_pc[PC_W-1:PC_TOP],
                            up_pc[PC_W-1:PC_TOP], lk_pc[PC_W-1:FB_TOP], up_pc[PC_W-1:FB_TOP]};

  ibp_hist #(.ID_W(ID_W), .EVENTS(HIST_EVENTS), .FOLD_W(SET_W)) i_hist (
    .clk(clk), .rst(rst), .shift_en(up_valid),
    .id_in(up_target[2 +: ID_W]), .hist(hist_q), .folded(folded)
  );

  assign lk_set = lk_pc[2 +: SET_W] ^ folded;
  assign up_set = up_pc[2 +: SET_W] ^ folded;
  assign lk_tag = {lk_pc[2+SET_W +: TAG_PC_W], hist_q};
  assign up_tag = {up_pc[2+SET_W +: TAG_PC_W], hist_q};

  ibp_target_table #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(PC_W)) i_table (
    .clk(clk), .rst(rst),
    .rd_set(lk_set), .rd_tag(lk_tag), .rd_hit(tt_hit), .rd_target(tt_tgt),
    .wr_en(up_valid), .wr_alloc(up_mispred), .wr_set(up_set), .wr_tag(up_tag),
    .wr_target(up_target)
  );

  ibp_fallback #(.IDX_W(FB_IDX_W), .TAG_W(TAG_PC_W), .TGT_W(PC_W)) i_last (
    .clk(clk), .rst(rst),
    .rd_idx(lk_pc[2 +: FB_IDX_W]), .rd_tag(lk_pc[2+FB_IDX_W +: TAG_PC_W]),
    .rd_hit(fb_hit), .rd_target(fb_tgt),
    .wr_en(up_valid), .wr_idx(up_pc[2 +: FB_IDX_W]),
    .wr_tag(up_pc[2+FB_IDX_W +: TAG_PC_W]), .wr_target(up_target)
  );

  always_comb begin
    if (tt_hit)      pick_tgt = tt_tgt;
    else if (fb_hit) pick_tgt = fb_tgt;
    else             pick_tgt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_tgt_q   <= '0;
    end else begin
      rsp_valid_q <= lk_valid;
      rsp_hit_q   <= lk_valid && (tt_hit || fb_hit);
      rsp_tgt_q   <= lk_valid ? pick_tgt : '0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_target = rsp_tgt_q;
endmodule

// File: rtl/ibp_predictor_chk.sv
module ibp_predictor_chk #(
  parameter int PC_W        = 32,
  parameter int ID_W        = 2,
  parameter int HIST_EVENTS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        lk_valid,
  input logic                        rsp_valid,
  input logic                        rsp_hit,
  input logic [PC_W-1:0]             rsp_target,
  input logic                        up_valid,
  input logic [ID_W-1:0]             up_id,
  input logic [ID_W*HIST_EVENTS-1:0] hist_q
);
  localparam int H_W = ID_W * HIST_EVENTS;

  // R2
  rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R3
  miss_zero_target_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_target == '0));

  // R7
  hist_newest_chk: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (hist_q[ID_W-1:0] == $past(up_id)));

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (hist_q[H_W-1:ID_W] == $past(hist_q[H_W-ID_W-1:0])));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(hist_q));
endmodule

bind ibp_predictor ibp_predictor_chk #(
  .PC_W(PC_W), .ID_W(ID_W), .HIST_EVENTS(HIST_EVENTS)
) i_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_target(rsp_target), .up_valid(up_valid),
  .up_id(up_target[2 +: ID_W]), .hist_q(hist_q)
);

// File: tb/test_ibp_predictor.sv
module test_ibp_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_target;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [31:0] up_target = '0;
  logic        up_mispred = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic        exp_hit_q [$];
  logic [31:0] exp_tgt_q [$];
  string       rid_q [$];

  localparam logic [31:0] TA = 32'h0000_4000, TB = 32'h0000_5000;
  localparam logic [31:0] TX = 32'h0000_6004, TY = 32'h0000_7008, TZ = 32'h0000_800C;

  always #5 clk = ~clk;

  ibp_predictor i_ibp_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target), .up_mispred(up_mispred)
  );

  task automatic chk(input bit ok, input string rid, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rid, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_hit_q.size() == 0) begin
        chk(1'b0, "R2 unexpected response", 32'd1, 32'd0);
      end else begin
        logic        eh;
        logic [31:0] et;
        string       rid;
        eh  = exp_hit_q.pop_front();
        et  = exp_tgt_q.pop_front();
        rid = rid_q.pop_front();
        chk(rsp_hit == eh, {rid, " hit"}, {31'd0, rsp_hit}, {31'd0, eh});
        chk(rsp_target == et, {rid, " target"}, rsp_target, et);
      end
    end
  end

  // All tasks start and end at a falling edge
  task automatic lookup(input logic [31:0] pc, input logic eh, input logic [31:0] et, input string rid);
    lk_valid = 1'b1;
    lk_pc    = pc;
    exp_hit_q.push_back(eh);
    exp_tgt_q.push_back(et);
    rid_q.push_back(rid);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic update(input logic [31:0] pc, input logic [31:0] tgt, input logic mis);
    up_valid   = 1'b1;
    up_pc      = pc;
    up_target  = tgt;
    up_mispred = mis;
    @(negedge clk);
    up_valid   = 1'b0;
  endtask

  task automatic exec(input logic [31:0] pc, input logic [31:0] tgt, input logic eh,
                      input logic [31:0] et, input string rid);
    lookup(pc, eh, et, rid);
    update(pc, tgt, !(eh && (et == tgt)));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 / R3: empty tables
    lookup(32'h0000_1000, 1'b0, 32'd0, "R1 R3 lookup after reset");
    @(negedge clk);

    // R4 R5 R6: single target, then a switch
    exec(32'h0000_1000, TA, 1'b0, 32'd0, "R3 first execution");
    exec(32'h0000_1000, TA, 1'b1, TA, "R4 last target");
    exec(32'h0000_1000, TA, 1'b1, TA, "R5 trained entry");
    exec(32'h0000_1000, TB, 1'b1, TA, "R6 before switch");
    exec(32'h0000_1000, TB, 1'b1, TB, "R4 R6 after switch");

    // R1: reset forgets everything
    do_reset();
    lookup(32'h0000_1000, 1'b0, 32'd0, "R1 cleared by reset");
    @(negedge clk);

    // R11: same-cycle lookup and update
    do_reset();
    exec(32'h0000_0600, TA, 1'b0, 32'd0, "R11 setup a");
    exec(32'h0000_0600, TA, 1'b1, TA, "R11 setup b");
    lk_valid = 1'b1; lk_pc = 32'h0000_0600;
    exp_hit_q.push_back(1'b1); exp_tgt_q.push_back(TA); rid_q.push_back("R11 old contents");
    up_valid = 1'b1; up_pc = 32'h0000_0600; up_target = TB; up_mispred = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    lookup(32'h0000_0600, 1'b1, TB, "R11 update applied");
    @(negedge clk);

    // R10: five PCs in one set, same fallback slot
    do_reset();
    for (int p = 1; p <= 4; p++)
      exec(32'(p) << 8, 32'h0001_0000 + (32'(p) << 8), 1'b0, 32'd0, "R10 fill");
    for (int p = 1; p <= 4; p++)
      exec(32'(p) << 8, 32'h0001_0000 + (32'(p) << 8), 1'b0, 32'd0, "R6 R10 confirm");
    for (int p = 1; p <= 4; p++)
      lookup(32'(p) << 8, 1'b1, 32'h0001_0000 + (32'(p) << 8), "R5 R10 resident");
    @(negedge clk);
    exec(32'h0000_0500, 32'h0001_0500, 1'b0, 32'd0, "R10 newcomer");
    lookup(32'h0000_0100, 1'b0, 32'd0, "R10 oldest evicted");
    lookup(32'h0000_0200, 1'b1, 32'h0001_0200, "R10 survivor b");
    lookup(32'h0000_0300, 1'b1, 32'h0001_0300, "R10 survivor c");
    @(negedge clk);

    // R7 R8: two-target alternation
    do_reset();
    for (int k = 0; k < 16; k++) begin
      logic [31:0] cur, prv;
      cur = (k % 2 == 0) ? TX : TY;
      prv = (k % 2 == 0) ? TY : TX;
      if (k == 0)     exec(32'h0000_2040, cur, 1'b0, 32'd0, "R8 first");
      else if (k < 8) exec(32'h0000_2040, cur, 1'b1, prv, "R4 R8 warmup");
      else            exec(32'h0000_2040, cur, 1'b1, cur, "R7 R8 learned");
    end

    // R7 R9: three-target rotation
    do_reset();
    for (int k = 0; k < 18; k++) begin
      logic [31:0] cur, prv;
      cur = (k % 3 == 0) ? TX : (k % 3 == 1) ? TY : TZ;
      prv = (k % 3 == 0) ? TZ : (k % 3 == 1) ? TX : TY;
      if (k == 0)      exec(32'h0000_3080, cur, 1'b0, 32'd0, "R9 first");
      else if (k < 10) exec(32'h0000_3080, cur, 1'b1, prv, "R4 R9 warmup");
      else             exec(32'h0000_3080, cur, 1'b1, cur, "R7 R9 learned");
    end

    repeat (3) @(negedge clk);
    chk(exp_hit_q.size() == 0, "R2 missing responses", 32'(exp_hit_q.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule